// File: doc/BRIEF.md
# Supply supervisor reset controller

This block is the digital half of a supply supervisor. It receives comparator flags that are already sampled into the clock domain: one says the main supply is under its lower threshold, the other says a second monitored supply is under its own threshold. It also receives a raw, bouncing, active-low manual reset pin, a watchdog kick and a watchdog interval select. From these it drives an active-low system reset, an early low-line warning, a second-supply fail output and an active-low watchdog timeout.

The delay rules differ by output. System reset is stretched: it is held while the main supply is low or the debounced manual reset is pressed, and for a fixed number of cycles after both have cleared. The low-line and second-supply outputs follow their comparator flags with no clocking. The watchdog interval is stored in a write-once register. The first write fixes the interval. Later writes have no effect, and system resets do not clear it. Only the power-on input `por_n` blanks it, which models the first start of a non-volatile store.

The reset sequencer has three states. `RS_HOLD` is entered from any state when a trigger is active. `RS_HOLD` goes to `RS_STRETCH` when the trigger clears. `RS_STRETCH` goes to `RS_RUN` when its counter reaches the stretch length, and goes back to `RS_HOLD` if a trigger returns. Power-on starts in `RS_STRETCH`. The watchdog also has three states. Every state goes to `WD_OFF` while reset is active or the watchdog is disabled. `WD_OFF` goes to `WD_COUNT` once reset is released and the watchdog is enabled. `WD_COUNT` goes to `WD_FIRED` when the interval expires. A kick sends `WD_COUNT` or `WD_FIRED` back to `WD_COUNT` with a cleared count.

Top module: `supply_supervisor`

## Requirements
- R1: While `vmain_low_i` is 1, `sys_rst_n_o` is 0 from the next clock cycle onward.
- R2: After every reset trigger has cleared, and after `por_n` is released, `sys_rst_n_o` stays 0 for `STRETCH_CYCLES` further cycles and then returns to 1.
- R3: If a trigger returns during the stretch, the stretch count starts again from zero once that trigger clears.
- R4: Holding `mr_pin_n` at 0 for longer than the debounce time drives `sys_rst_n_o` to 0. Reset stays 0 while the pin is held and for the full stretch after the debounced release.
- R5: A low pulse on `mr_pin_n` shorter than `DEB_CYCLES` cycles has no effect on `sys_rst_n_o`.
- R6: `lowline_n_o` is the inverse of `vmain_low_i`, with no clock delay.
- R7: `aux_fail_n_o` is the inverse of `vaux_low_i`, with no clock delay and no power-up stretch.
- R8: If no kick arrives for the selected interval, `wd_timeout_n_o` goes to 0. It stays 0 until a kick and returns to 1 in the cycle after that kick.
- R9: The interval code on `wd_sel_i` selects 2'b00 = `WD_SHORT`, 2'b01 = `WD_MED`, 2'b10 = `WD_LONG` cycles. 2'b11 disables the watchdog. While no code has been written, the watchdog is also disabled.
- R10: The first cycle with `wd_sel_wr_i` = 1 stores `wd_sel_i` for good. Later writes are ignored, and the stored value survives system resets. Only `por_n` clears it.
- R11: While `sys_rst_n_o` is 0, the watchdog count is cleared and `wd_timeout_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on initialisation, active low, asynchronous |
| vmain_low_i | input | 1 | Main supply below threshold 1 |
| vaux_low_i | input | 1 | Second supply below threshold 2 |
| mr_pin_n | input | 1 | Raw manual reset pin, active low |
| wd_kick_i | input | 1 | Watchdog restart, one pulse per kick |
| wd_sel_i | input | 2 | Watchdog interval code |
| wd_sel_wr_i | input | 1 | Write strobe for the interval code |
| sys_rst_n_o | output | 1 | System reset, active low |
| lowline_n_o | output | 1 | Early low-line warning, active low |
| aux_fail_n_o | output | 1 | Second-supply fail, active low |
| wd_timeout_n_o | output | 1 | Watchdog timeout, active low |

## Verification
The bench builds the block with `DEB_CYCLES` = 4, `STRETCH_CYCLES` = 12 and watchdog intervals of 20, 40 and 80 cycles. With these values, every stretch, restart, debounce filter and watchdog expiry finishes within a few dozen cycles, so each one can be checked on both sides of its boundary. The short intervals also let the bench re-initialise the block through `por_n` and program each of the three intervals and the disable code in a single run.

// File: rtl/sup_pkg.sv
`timescale 1ns/1ps
package sup_pkg;
    typedef enum logic [1:0] {
        RS_HOLD    = 2'd0,
        RS_STRETCH = 2'd1,
        RS_RUN     = 2'd2
    } rst_state_t;

    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_COUNT = 2'd1,
        WD_FIRED = 2'd2
    } wd_state_t;

    localparam logic [1:0] SEL_SHORT = 2'b00;
    localparam logic [1:0] SEL_MED   = 2'b01;
    localparam logic [1:0] SEL_LONG  = 2'b10;
    localparam logic [1:0] SEL_OFF   = 2'b11;
endpackage

// File: rtl/sup_debounce.sv
`timescale 1ns/1ps
// Two-flop synchroniser followed by a stability filter on an active-low pin.
module sup_debounce #(
    parameter int unsigned DEB_CYCLES = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic raw_n,
    output logic pressed
);
    localparam int CW = $clog2(DEB_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

    logic          sync1_n, sync2_n;
    logic          stable_n;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sync1_n <= 1'b1;
            sync2_n <= 1'b1;
        end else begin
            sync1_n <= raw_n;
            sync2_n <= sync1_n;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            stable_n <= 1'b1;
            cnt      <= '0;
        end else if (sync2_n == stable_n) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            stable_n <= sync2_n;
            cnt      <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign pressed = !stable_n;
endmodule

// File: rtl/sup_reset_fsm.sv
`timescale 1ns/1ps
// Reset sequencer: hold while triggered, then stretch for a fixed count.
module sup_reset_fsm
    import sup_pkg::*;
#(
    parameter int unsigned STRETCH_CYCLES = 2000
) (
    input  logic clk,
    input  logic por_n,
    input  logic trigger,
    output logic sys_rst_n
);
    localparam int CW = $clog2(STRETCH_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(STRETCH_CYCLES - 1);

    rst_state_t    state, nxt;
    logic [CW-1:0] cnt;

    // State register and stretch counter.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state <= RS_STRETCH;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == RS_STRETCH && nxt == RS_STRETCH)
                cnt <= cnt + 1'b1;
            else
                cnt <= '0;
        end
    end

    // Transitions.
    always_comb begin
        nxt = state;
        unique case (state)
            RS_HOLD:    nxt = trigger ? RS_HOLD : RS_STRETCH;
            RS_STRETCH: begin
                if (trigger)          nxt = RS_HOLD;
                else if (cnt == LAST) nxt = RS_RUN;
                else                  nxt = RS_STRETCH;
            end
            RS_RUN:     nxt = trigger ? RS_HOLD : RS_RUN;
            default:    nxt = RS_HOLD;
        endcase
    end

    // Outputs.
    always_comb begin
        sys_rst_n = (state == RS_RUN);
    end
endmodule

// File: rtl/sup_watchdog.sv
`timescale 1ns/1ps
// Watchdog with a write-once interval register.
module sup_watchdog
    import sup_pkg::*;
#(
    parameter int unsigned WD_SHORT = 10000,
    parameter int unsigned WD_MED   = 50000,
    parameter int unsigned WD_LONG  = 200000
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       run,
    input  logic       kick,
    input  logic       sel_wr,
    input  logic [1:0] sel,
    output logic       timeout_n,
    output logic [1:0] sel_q,
    output logic       locked
);
    localparam int unsigned MAX_AB  = (WD_SHORT > WD_MED) ? WD_SHORT : WD_MED;
    localparam int unsigned MAX_CYC = (MAX_AB > WD_LONG) ? MAX_AB : WD_LONG;
    localparam int CW = $clog2(MAX_CYC + 1);

    wd_state_t     state, nxt;
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim_m1;
    logic          enabled;

    // Sticky interval store, blanked only at power-on.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sel_q  <= SEL_OFF;
            locked <= 1'b0;
        end else if (sel_wr && !locked) begin
            sel_q  <= sel;
            locked <= 1'b1;
        end
    end

    assign enabled = locked && (sel_q != SEL_OFF);

    always_comb begin
        case (sel_q)
            SEL_SHORT: lim_m1 = CW'(WD_SHORT - 1);
            SEL_MED:   lim_m1 = CW'(WD_MED - 1);
            default:   lim_m1 = CW'(WD_LONG - 1);
        endcase
    end

    // State register and interval counter.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state <= WD_OFF;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == WD_COUNT && nxt == WD_COUNT && !kick)
                cnt <= cnt + 1'b1;
            else
                cnt <= '0;
        end
    end

    // Transitions.
    always_comb begin
        nxt = state;
        if (!run || !enabled) begin
            nxt = WD_OFF;
        end else begin
            unique case (state)
                WD_OFF:   nxt = WD_COUNT;
                WD_COUNT: begin
                    if (kick)                nxt = WD_COUNT;
                    else if (cnt == lim_m1)  nxt = WD_FIRED;
                    else                     nxt = WD_COUNT;
                end
                WD_FIRED: nxt = kick ? WD_COUNT : WD_FIRED;
                default:  nxt = WD_OFF;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        timeout_n = (state != WD_FIRED);
    end
endmodule

// File: rtl/supply_supervisor.sv
`timescale 1ns/1ps
module supply_supervisor #(
    parameter int unsigned DEB_CYCLES     = 16,
    parameter int unsigned STRETCH_CYCLES = 2000,
    parameter int unsigned WD_SHORT       = 10000,
    parameter int unsigned WD_MED         = 50000,
    parameter int unsigned WD_LONG        = 200000
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       vmain_low_i,
    input  logic       vaux_low_i,
    input  logic       mr_pin_n,
    input  logic       wd_kick_i,
    input  logic [1:0] wd_sel_i,
    input  logic       wd_sel_wr_i,
    output logic       sys_rst_n_o,
    output logic       lowline_n_o,
    output logic       aux_fail_n_o,
    output logic       wd_timeout_n_o
);
    logic       mr_pressed;
    logic       rst_trigger;
    logic [1:0] wd_sel_q;
    logic       wd_locked;

    sup_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
        .clk     (clk),
        .por_n   (por_n),
        .raw_n   (mr_pin_n),
        .pressed (mr_pressed)
    );

    assign rst_trigger = vmain_low_i | mr_pressed;

    sup_reset_fsm #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_rst (
        .clk       (clk),
        .por_n     (por_n),
        .trigger   (rst_trigger),
        .sys_rst_n (sys_rst_n_o)
    );

    sup_watchdog #(
        .WD_SHORT (WD_SHORT),
        .WD_MED   (WD_MED),
        .WD_LONG  (WD_LONG)
    ) u_wd (
        .clk       (clk),
        .por_n     (por_n),
        .run       (sys_rst_n_o),
        .kick      (wd_kick_i),
        .sel_wr    (wd_sel_wr_i),
        .sel       (wd_sel_i),
        .timeout_n (wd_timeout_n_o),
        .sel_q     (wd_sel_q),
        .locked    (wd_locked)
    );

    assign lowline_n_o  = !vmain_low_i;
    assign aux_fail_n_o = !vaux_low_i;
endmodule

// File: rtl/sup_checker.sv
`timescale 1ns/1ps
module sup_checker #(
    parameter int unsigned STRETCH_CYCLES = 2000
) (
    input logic       clk,
    input logic       por_n,
    input logic       vmain_low_i,
    input logic       mr_pressed,
    input logic       sys_rst_n_o,
    input logic       wd_kick_i,
    input logic       wd_timeout_n_o,
    input logic [1:0] wd_sel_q,
    input logic       wd_locked
);
    localparam int QW = $clog2(STRETCH_CYCLES + 3);

    // Quiet cycles spent in reset with no trigger present.
    logic [QW-1:0] quiet;
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                        quiet <= '0;
        else if (vmain_low_i || mr_pressed) quiet <= '0;
        else if (sys_rst_n_o)              quiet <= '0;
        else if (quiet != '1)              quiet <= quiet + 1'b1;
    end

    assert_supply_low_resets_R1: assert property (@(posedge clk) disable iff (!por_n)
        vmain_low_i |=> !sys_rst_n_o);

    assert_stretch_elapsed_R2: assert property (@(posedge clk) disable iff (!por_n)
        $rose(sys_rst_n_o) |-> (quiet >= QW'(STRETCH_CYCLES)));

    assert_kick_clears_timeout_R8: assert property (@(posedge clk) disable iff (!por_n)
        wd_kick_i |=> wd_timeout_n_o);

    assert_interval_sticky_R10: assert property (@(posedge clk) disable iff (!por_n)
        wd_locked |=> (wd_locked && $stable(wd_sel_q)));

    assert_wd_quiet_in_reset_R11: assert property (@(posedge clk) disable iff (!por_n)
        !sys_rst_n_o |=> wd_timeout_n_o);
endmodule

bind supply_supervisor sup_checker #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_chk (
    .clk            (clk),
    .por_n          (por_n),
    .vmain_low_i    (vmain_low_i),
    .mr_pressed     (mr_pressed),
    .sys_rst_n_o    (sys_rst_n_o),
    .wd_kick_i      (wd_kick_i),
    .wd_timeout_n_o (wd_timeout_n_o),
    .wd_sel_q       (wd_sel_q),
    .wd_locked      (wd_locked)
);

// File: tb/test_supply_supervisor.sv
`timescale 1ns/1ps
module test_supply_supervisor;
    localparam int unsigned DEB = 4;
    localparam int unsigned STR = 12;
    localparam int unsigned WS  = 20;
    localparam int unsigned WM  = 40;
    localparam int unsigned WL  = 80;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       vmain_low_i = 1'b0;
    logic       vaux_low_i = 1'b0;
    logic       mr_pin_n = 1'b1;
    logic       wd_kick_i = 1'b0;
    logic [1:0] wd_sel_i = 2'b00;
    logic       wd_sel_wr_i = 1'b0;
    logic       sys_rst_n_o, lowline_n_o, aux_fail_n_o, wd_timeout_n_o;

    int n_vec  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    supply_supervisor #(
        .DEB_CYCLES(DEB), .STRETCH_CYCLES(STR),
        .WD_SHORT(WS), .WD_MED(WM), .WD_LONG(WL)
    ) i_supply_supervisor (
        .clk(clk), .por_n(por_n), .vmain_low_i(vmain_low_i), .vaux_low_i(vaux_low_i),
        .mr_pin_n(mr_pin_n), .wd_kick_i(wd_kick_i), .wd_sel_i(wd_sel_i),
        .wd_sel_wr_i(wd_sel_wr_i), .sys_rst_n_o(sys_rst_n_o), .lowline_n_o(lowline_n_o),
        .aux_fail_n_o(aux_fail_n_o), .wd_timeout_n_o(wd_timeout_n_o)
    );

    // {vmain_low, vaux_low, expected lowline_n, expected aux_fail_n}
    localparam logic [3:0] VEC [8] = '{
        4'b0011, 4'b1001, 4'b0110, 4'b1100,
        4'b0011, 4'b0110, 4'b1001, 4'b0011
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic power_on();
        por_n = 1'b0;
        tick(3);
        por_n = 1'b1;
        tick(STR + 3);
    endtask

    task automatic kick();
        wd_kick_i = 1'b1;
        tick(1);
        wd_kick_i = 1'b0;
    endtask

    task automatic write_sel(input logic [1:0] code);
        wd_sel_i    = code;
        wd_sel_wr_i = 1'b1;
        tick(1);
        wd_sel_wr_i = 1'b0;
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        // Reset state (R2)
        tick(2);
        chk("R2 reset low during por", sys_rst_n_o, 1'b0);
        por_n = 1'b1;
        tick(2);
        chk("R2 reset low early in power-up stretch", sys_rst_n_o, 1'b0);
        chk("R8 timeout inactive after power-up", wd_timeout_n_o, 1'b1);
        tick(STR + 1);
        chk("R2 reset released after power-up stretch", sys_rst_n_o, 1'b1);

        // Vector table: comparator-following outputs (R6, R7)
        foreach (VEC[i]) begin
            vmain_low_i = VEC[i][3];
            vaux_low_i  = VEC[i][2];
            #1;
            chk("R6 lowline follows main flag", lowline_n_o, VEC[i][1]);
            chk("R7 aux fail follows second flag", aux_fail_n_o, VEC[i][0]);
            tick(1);
        end
        vmain_low_i = 1'b0;
        vaux_low_i  = 1'b0;
        tick(STR + 4);
        chk("R2 reset released after vector walk", sys_rst_n_o, 1'b1);

        // R1 and R2: supply low, then stretch
        vmain_low_i = 1'b1;
        tick(1);
        chk("R1 reset asserted after supply low", sys_rst_n_o, 1'b0);
        tick(5);
        chk("R1 reset held while supply low", sys_rst_n_o, 1'b0);
        vmain_low_i = 1'b0;
        tick(STR - 1);
        chk("R2 reset still low before stretch end", sys_rst_n_o, 1'b0);
        tick(4);
        chk("R2 reset released after stretch", sys_rst_n_o, 1'b1);

        // R3: restart of stretch
        vmain_low_i = 1'b1;
        tick(3);
        vmain_low_i = 1'b0;
        tick(STR / 2);
        vmain_low_i = 1'b1;
        tick(1);
        vmain_low_i = 1'b0;
        tick(STR - 1);
        chk("R3 stretch restarted after re-trigger", sys_rst_n_o, 1'b0);
        tick(4);
        chk("R3 reset released after restarted stretch", sys_rst_n_o, 1'b1);

        // R5: short glitch on the manual pin is filtered
        begin
            logic seen_low = 1'b0;
            mr_pin_n = 1'b0;
            tick(DEB - 2);
            mr_pin_n = 1'b1;
            for (int k = 0; k < 15; k++) begin
                tick(1);
                if (!sys_rst_n_o) seen_low = 1'b1;
            end
            chk("R5 short manual glitch ignored", seen_low, 1'b0);
        end

        // R4: held manual reset
        mr_pin_n = 1'b0;
        tick(20);
        chk("R4 manual reset asserts reset", sys_rst_n_o, 1'b0);
        mr_pin_n = 1'b1;
        tick(DEB + STR - 2);
        chk("R4 reset held through debounce and stretch", sys_rst_n_o, 1'b0);
        tick(10);
        chk("R4 reset released after manual stretch", sys_rst_n_o, 1'b1);

        // R9: unprogrammed watchdog is disabled
        tick(100);
        chk("R9 unprogrammed watchdog stays quiet", wd_timeout_n_o, 1'b1);

        // R8: short interval with regular kicks, then expiry
        write_sel(2'b00);
        for (int k = 0; k < 6; k++) begin
            kick();
            tick(9);
        end
        chk("R8 regular kicks prevent timeout", wd_timeout_n_o, 1'b1);
        kick();
        tick(WS - 5);
        chk("R8 no timeout before short interval", wd_timeout_n_o, 1'b1);
        tick(10);
        chk("R8 timeout after short interval", wd_timeout_n_o, 1'b0);
        tick(10);
        chk("R8 timeout held until kick", wd_timeout_n_o, 1'b0);
        kick();
        chk("R8 kick clears timeout", wd_timeout_n_o, 1'b1);

        // R10: second write ignored
        write_sel(2'b11);
        kick();
        tick(WS + 5);
        chk("R10 later write ignored, short interval kept", wd_timeout_n_o, 1'b0);
        kick();

        // R11 and R10: watchdog cleared during reset, interval survives reset
        vmain_low_i = 1'b1;
        tick(50);
        chk("R11 watchdog quiet while in reset", wd_timeout_n_o, 1'b1);
        vmain_low_i = 1'b0;
        tick(STR + 1 + WS - 5);
        chk("R11 watchdog restarts from zero after reset", wd_timeout_n_o, 1'b1);
        tick(12);
        chk("R10 interval survives system reset", wd_timeout_n_o, 1'b0);
        kick();

        // R9: medium interval
        power_on();
        write_sel(2'b01);
        kick();
        tick(WM - 5);
        chk("R9 no timeout before medium interval", wd_timeout_n_o, 1'b1);
        tick(10);
        chk("R9 timeout after medium interval", wd_timeout_n_o, 1'b0);

        // R9: long interval
        power_on();
        write_sel(2'b10);
        kick();
        tick(WL - 5);
        chk("R9 no timeout before long interval", wd_timeout_n_o, 1'b1);
        tick(10);
        chk("R9 timeout after long interval", wd_timeout_n_o, 1'b0);

        // R9: disable code
        power_on();
        write_sel(2'b11);
        kick();
        tick(200);
        chk("R9 code 11 disables watchdog", wd_timeout_n_o, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule